// File: doc/BRIEF.md
# Clock-Sampled EDO DRAM Pin Model

This block is a synthesizable, clock-sampled model of the control side of a 16-bit extended-data-out DRAM. A verification environment or a memory controller under test uses it as a target. The model samples the active-low strobes, the multiplexed address and the write data on each rising clock edge. It latches a row when the row strobe falls and a column when the first column strobe falls. It classifies each access and serves it from a small internal array whose depth is a parameter. The row and column are folded into that reduced index space.

Every access sorts into one kind: standby, row-only refresh, a byte or word read, an early write, or a read-modify-write. The choice depends on the order in which the row strobe, the column strobes and the write enable change. A column strobe already low when the row strobe falls starts a refresh that uses no address. That refresh advances a 10-bit internal counter, which is brought out so that its progress can be seen. Read data leaves through a 16-bit bus with one enable per byte lane. After a column strobe rises, read data stays on the bus until output enable rises, write enable falls or the row strobe rises.

Top module: `edo_dram_model`

## Requirements
- R1: One clock after a sample with `rasN` high, `doutEn` is 00, whatever the column strobes, `weN` and `oeN` are doing.
- R2: An access in which `rasN` is low and both column strobes stay high (row-only refresh) never enables an output, writes nothing and leaves `refreshCount` unchanged.
- R3: In a read, `weN` is high when the first column strobe falls. One clock after a sample with `oeN` low, `doutEn[0]` follows a low `lcasN` and `doutEn[1]` follows a low `ucasN`. The lanes carry the stored byte at index `{row[3:0], col[3:0]}`, with lane 0 on bits 7:0 and lane 1 on bits 15:8. With `oeN` high, both enables are off.
- R4: The column is taken from `addr` on the edge where the first of the two column strobes falls. A later fall of the other strobe in the same access reuses that column.
- R5: An early write has `weN` already low when the first column strobe falls. It writes `din` into each lane whose strobe is low, and no output enable turns on for the rest of that column access, even if `weN` later rises with `oeN` low.
- R6: In a read-modify-write, the read data appears first. When `weN` then falls with a column strobe low, `din` is written into the lanes whose strobe is low, the outputs turn off, and they stay off for the rest of the column access.
- R7: While a lane's column strobe is high, its output data does not change. An enabled lane stays enabled after its strobe rises, until `oeN` goes high, `weN` goes low or `rasN` goes high.
- R8: When `rasN` falls with a column strobe already low, the access is a refresh. It performs no read and no write. `refreshCount` rises by exactly one on the edge where `rasN` returns high, and wraps from 1023 to 0.
- R9: Within one low period of `rasN`, each new first fall of the column strobes latches a new column and returns that column's data (page mode).
- R10: After reset, `doutEn` is 00, `refreshCount` is 0 and every stored word reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rasN | input | 1 | Row strobe, active low |
| lcasN | input | 1 | Column strobe for lane 0 (bits 7:0), active low |
| ucasN | input | 1 | Column strobe for lane 1 (bits 15:8), active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | 16 | Write data |
| dout | output | 16 | Read data |
| doutEn | output | 2 | Per-lane output drive enable (bit 0 lane 0) |
| refreshCount | output | REF_W | Internal refresh row counter |

## Verification
The assertions assume that the pins change only between clock edges and that the sampled strobe sequence looks like a legal controller's. The bench never lowers the row strobe and a column strobe on the same sample, and it never moves the address while it is latching. Every directed and random access is therefore built from task sequences. Each of these returns all strobes high before the next access starts, so no access can be misread as a refresh by accident. Only the R1 step and the refresh task lower a column strobe while `rasN` is high, and both raise it again before any normal access begins.

// File: rtl/edo_pkg.sv
`timescale 1ns/1ps
package edo_pkg;
  localparam int LANES  = 2;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_REFRESH,
    ACC_READ,
    ACC_EWRITE,
    ACC_WDONE
  } accKind_t;

  typedef struct packed {
    logic             rowLoad;
    logic             colLoad;
    logic [LANES-1:0] wrLane;
    logic [LANES-1:0] rdLane;
    logic [LANES-1:0] drvOn;
    logic             refInc;
  } edoStrobe_t;
endpackage

// File: rtl/edo_ctrl.sv
`timescale 1ns/1ps
module edo_ctrl
  import edo_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rasN,
  input  logic [LANES-1:0] casN,
  input  logic             weN,
  input  logic             oeN,
  input  logic [LANES-1:0] doutEn,
  output edoStrobe_t       stb
);
  logic             rasQ;
  logic             weQ;
  logic [LANES-1:0] casLowQ;
  accKind_t         modeQ;
  accKind_t         modeNext;

  logic [LANES-1:0] casLow;
  logic [LANES-1:0] laneFell;
  logic             rasFall;
  logic             rasRise;
  logic             firstFall;
  logic             weFell;
  logic             accOn;

  always_comb begin
    casLow    = ~casN;
    laneFell  = ~casLowQ & casLow;
    rasFall   = rasQ & ~rasN;
    rasRise   = ~rasQ & rasN;
    firstFall = ~(|casLowQ) & (|casLow);
    weFell    = weQ & ~weN;
    stb       = '0;
    modeNext  = modeQ;

    if (rasN) begin
      modeNext = ACC_IDLE;
    end else begin
      if (rasFall) begin
        modeNext = (|casLowQ) ? ACC_REFRESH : ACC_IDLE;
      end
      if (modeNext != ACC_REFRESH && firstFall) begin
        modeNext    = weN ? ACC_READ : ACC_EWRITE;
        stb.colLoad = 1'b1;
      end
    end

    stb.rowLoad = rasFall & ~(|casLowQ);
    accOn = ~rasN & (modeNext == ACC_READ || modeNext == ACC_EWRITE ||
                     modeNext == ACC_WDONE);

    for (int i = 0; i < LANES; i++) begin
      stb.wrLane[i] = accOn & ~weN & casLow[i] & (laneFell[i] | weFell);
    end

    if (modeNext == ACC_READ && (|stb.wrLane)) begin
      modeNext = ACC_WDONE;
    end

    for (int i = 0; i < LANES; i++) begin
      stb.rdLane[i] = ~rasN & (modeNext == ACC_READ) & casLow[i];
      stb.drvOn[i]  = ~rasN & ~oeN & weN & (modeNext == ACC_READ) &
                      (casLow[i] | doutEn[i]);
    end

    stb.refInc = rasRise & (modeQ == ACC_REFRESH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rasQ    <= 1'b1;
      weQ     <= 1'b1;
      casLowQ <= '0;
      modeQ   <= ACC_IDLE;
    end else begin
      rasQ    <= rasN;
      weQ     <= weN;
      casLowQ <= ~casN;
      modeQ   <= modeNext;
    end
  end
endmodule

// File: rtl/edo_datapath.sv
`timescale 1ns/1ps
module edo_datapath
  import edo_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DEPTH  = 256,
  parameter int REF_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  edoStrobe_t        stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [LANES-1:0]  doutEn,
  output logic [REF_W-1:0]  refreshCount
);
  localparam int IDX_W    = $clog2(DEPTH);
  localparam int COL_BITS = IDX_W / 2;
  localparam int ROW_BITS = IDX_W - COL_BITS;

  logic [ADDR_W-1:0] rowQ;
  logic [ADDR_W-1:0] colQ;
  logic [ADDR_W-1:0] rowEff;
  logic [ADDR_W-1:0] colEff;
  logic [IDX_W-1:0]  idx;

  assign rowEff = stb.rowLoad ? addr : rowQ;
  assign colEff = stb.colLoad ? addr : colQ;
  assign idx    = {rowEff[ROW_BITS-1:0], colEff[COL_BITS-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rowQ         <= '0;
      colQ         <= '0;
      doutEn       <= '0;
      refreshCount <= '0;
    end else begin
      if (stb.rowLoad) rowQ <= addr;
      if (stb.colLoad) colQ <= addr;
      doutEn <= stb.drvOn;
      if (stb.refInc) refreshCount <= refreshCount + 1'b1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] store [DEPTH];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int k = 0; k < DEPTH; k++) store[k] <= '0;
        dout[g*LANE_W +: LANE_W] <= '0;
      end else begin
        if (stb.wrLane[g]) store[idx] <= din[g*LANE_W +: LANE_W];
        if (stb.rdLane[g]) dout[g*LANE_W +: LANE_W] <= store[idx];
      end
    end
  end
endmodule

// File: rtl/edo_dram_model.sv
`timescale 1ns/1ps
module edo_dram_model
  import edo_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DEPTH  = 256,
  parameter int REF_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasN,
  input  logic              lcasN,
  input  logic              ucasN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       din,
  output logic [15:0]       dout,
  output logic [1:0]        doutEn,
  output logic [REF_W-1:0]  refreshCount
);
  edoStrobe_t stb;

  edo_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .rasN   (rasN),
    .casN   ({ucasN, lcasN}),
    .weN    (weN),
    .oeN    (oeN),
    .doutEn (doutEn),
    .stb    (stb)
  );

  edo_datapath #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH),
    .REF_W  (REF_W)
  ) uData (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .addr         (addr),
    .din          (din),
    .dout         (dout),
    .doutEn       (doutEn),
    .refreshCount (refreshCount)
  );
endmodule

// File: rtl/edo_dram_chk.sv
`timescale 1ns/1ps
module edo_dram_chk #(
  parameter int REF_W = 10
) (
  input logic             clk,
  input logic             rstN,
  input logic             rasN,
  input logic             lcasN,
  input logic             ucasN,
  input logic             weN,
  input logic             oeN,
  input logic [15:0]      dout,
  input logic [1:0]       doutEn,
  input logic [REF_W-1:0] refreshCount
);
  AST_RAS_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    rasN |=> (doutEn == 2'b00)); // R1

  AST_OE_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    oeN |=> (doutEn == 2'b00)); // R3

  AST_WE_LOW_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !weN |=> (doutEn == 2'b00)); // R5

  AST_LOW_LANE_NEEDS_CAS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doutEn[0]) |-> !$past(lcasN)); // R3

  AST_HIGH_LANE_NEEDS_CAS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doutEn[1]) |-> !$past(ucasN)); // R3

  AST_LOW_LANE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    lcasN |=> $stable(dout[7:0])); // R7

  AST_HIGH_LANE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ucasN |=> $stable(dout[15:8])); // R7

  AST_REFRESH_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (refreshCount != $past(refreshCount)) |->
      (refreshCount == $past(refreshCount) + {{(REF_W-1){1'b0}}, 1'b1})); // R8
endmodule

bind edo_dram_model edo_dram_chk #(.REF_W(REF_W)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .rasN         (rasN),
  .lcasN        (lcasN),
  .ucasN        (ucasN),
  .weN          (weN),
  .oeN          (oeN),
  .dout         (dout),
  .doutEn       (doutEn),
  .refreshCount (refreshCount)
);

// File: tb/edo_dram_model_test.sv
`timescale 1ns/1ps
module edo_dram_model_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rasN = 1'b1, lcasN = 1'b1, ucasN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [9:0]  addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic [1:0]  doutEn;
  logic [9:0]  refreshCount;

  int nChecks = 0;
  int nBad = 0;
  bit finished = 0;
  logic [15:0] refMem [256];
  int refCnt = 0;

  always #2.5 clk = ~clk;

  edo_dram_model uut (
    .clk(clk), .rstN(rstN), .rasN(rasN), .lcasN(lcasN), .ucasN(ucasN),
    .weN(weN), .oeN(oeN), .addr(addr), .din(din), .dout(dout),
    .doutEn(doutEn), .refreshCount(refreshCount)
  );

  function automatic int idxOf(logic [9:0] r, logic [9:0] c);
    return int'({r[3:0], c[3:0]});
  endfunction

  function automatic logic [15:0] laneMask(logic [1:0] l);
    return {{8{l[1]}}, {8{l[0]}}};
  endfunction

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic chkEq(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle;
    rasN = 1'b1; lcasN = 1'b1; ucasN = 1'b1; weN = 1'b1; oeN = 1'b1;
    tick;
  endtask

  task automatic doRead(logic [9:0] r, logic [9:0] c, logic [1:0] l, int rel);
    logic [15:0] m, held;
    int i;
    i = idxOf(r, c);
    m = laneMask(l);
    idle;
    oeN = 1'b0; addr = r; rasN = 1'b0; tick;
    addr = c; lcasN = ~l[0]; ucasN = ~l[1]; tick;
    chkEq("R3 lane enable", 32'(doutEn), 32'(l));
    chkEq("R3 read data", 32'(dout & m), 32'(refMem[i] & m));
    held = dout;
    lcasN = 1'b1; ucasN = 1'b1; addr = ~c; tick;
    chkEq("R7 hold enable", 32'(doutEn), 32'(l));
    chkEq("R7 hold data", 32'(dout & m), 32'(held & m));
    case (rel)
      0: oeN = 1'b1;
      1: weN = 1'b0;
      default: rasN = 1'b1;
    endcase
    tick;
    chkEq("R7 release", 32'(doutEn), 32'd0);
    idle;
  endtask

  task automatic doEarlyWrite(logic [9:0] r, logic [9:0] c, logic [1:0] l, logic [15:0] d);
    logic [15:0] m;
    int i;
    i = idxOf(r, c);
    m = laneMask(l);
    idle;
    addr = r; rasN = 1'b0; tick;
    weN = 1'b0; din = d; addr = c; lcasN = ~l[0]; ucasN = ~l[1]; tick;
    chkEq("R5 no drive during write", 32'(doutEn), 32'd0);
    weN = 1'b1; oeN = 1'b0; tick;
    chkEq("R5 still quiet after WE rise", 32'(doutEn), 32'd0);
    refMem[i] = (refMem[i] & ~m) | (d & m);
    idle;
  endtask

  task automatic doRmw(logic [9:0] r, logic [9:0] c, logic [1:0] l, logic [15:0] d);
    logic [15:0] m;
    int i;
    i = idxOf(r, c);
    m = laneMask(l);
    idle;
    oeN = 1'b0; addr = r; rasN = 1'b0; tick;
    addr = c; lcasN = ~l[0]; ucasN = ~l[1]; tick;
    chkEq("R6 read phase enable", 32'(doutEn), 32'(l));
    chkEq("R6 read phase data", 32'(dout & m), 32'(refMem[i] & m));
    din = d; weN = 1'b0; tick;
    chkEq("R6 off after WE fall", 32'(doutEn), 32'd0);
    refMem[i] = (refMem[i] & ~m) | (d & m);
    weN = 1'b1; tick;
    chkEq("R6 stays off", 32'(doutEn), 32'd0);
    idle;
  endtask

  task automatic doCbr(bit doChk);
    idle;
    lcasN = 1'b0; ucasN = 1'b0; weN = 1'b0; oeN = 1'b0; din = 16'hdead;
    addr = 10'h053; tick;
    rasN = 1'b0; tick;
    if (doChk) chkEq("R8 refresh quiet", 32'(doutEn), 32'd0);
    rasN = 1'b1; tick;
    refCnt = (refCnt + 1) % 1024;
    if (doChk) chkEq("R8 counter step", 32'(refreshCount), 32'(refCnt));
    idle;
  endtask

  task automatic doRasOnly(logic [9:0] r);
    idle;
    addr = r; rasN = 1'b0; weN = 1'b0; oeN = 1'b0; din = 16'h7777; tick;
    tick;
    chkEq("R2 no drive", 32'(doutEn), 32'd0);
    rasN = 1'b1; tick;
    chkEq("R2 counter unchanged", 32'(refreshCount), 32'(refCnt));
    idle;
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", nChecks, nBad);
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      summary;
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int k = 0; k < 256; k++) refMem[k] = '0;
    repeat (3) tick;
    chkEq("R10 reset enable", 32'(doutEn), 32'd0);
    chkEq("R10 reset counter", 32'(refreshCount), 32'd0);
    rstN = 1'b1;
    tick;

    doRead(10'd5, 10'd3, 2'b11, 0);        // R10 zero contents
    doEarlyWrite(10'd5, 10'd3, 2'b11, 16'ha5c3);
    doRead(10'd5, 10'd3, 2'b11, 0);
    doEarlyWrite(10'd5, 10'd3, 2'b01, 16'h1234);
    doRead(10'd5, 10'd3, 2'b10, 1);
    doRead(10'd5, 10'd3, 2'b01, 2);

    // R1: strobes active while row strobe high
    idle;
    lcasN = 1'b0; ucasN = 1'b0; oeN = 1'b0; weN = 1'b1; tick;
    chkEq("R1 idle quiet", 32'(doutEn), 32'd0);
    idle;

    // R3: WE and OE both high
    addr = 10'd5; rasN = 1'b0; tick;
    addr = 10'd3; lcasN = 1'b0; ucasN = 1'b0; tick;
    chkEq("R3 OE high quiet", 32'(doutEn), 32'd0);
    idle;

    doRmw(10'd7, 10'd9, 2'b10, 16'hbeef);
    doRead(10'd7, 10'd9, 2'b11, 0);

    // R4: skewed strobes use first column
    doEarlyWrite(10'd2, 10'd4, 2'b11, 16'h1111);
    doEarlyWrite(10'd2, 10'd6, 2'b11, 16'h2222);
    idle;
    oeN = 1'b0; addr = 10'd2; rasN = 1'b0; tick;
    addr = 10'd4; lcasN = 1'b0; tick;
    addr = 10'd6; ucasN = 1'b0; tick;
    chkEq("R4 both lanes on", 32'(doutEn), 32'h3);
    chkEq("R4 first column data", 32'(dout), 32'(refMem[idxOf(10'd2, 10'd4)]));
    idle;

    // R9: page mode
    doEarlyWrite(10'd3, 10'd1, 2'b11, 16'h0a01);
    doEarlyWrite(10'd3, 10'd2, 2'b11, 16'h0b02);
    doEarlyWrite(10'd3, 10'd3, 2'b11, 16'h0c03);
    idle;
    oeN = 1'b0; addr = 10'd3; rasN = 1'b0; tick;
    for (int c = 1; c <= 3; c++) begin
      addr = 10'(c); lcasN = 1'b0; ucasN = 1'b0; tick;
      chkEq("R9 page data", 32'(dout), 32'(refMem[idxOf(10'd3, 10'(c))]));
      lcasN = 1'b1; ucasN = 1'b1; tick;
    end
    idle;

    // R8 and R2: refresh leaves data alone
    doCbr(1'b1);
    doRead(10'd5, 10'd3, 2'b11, 0);
    doRasOnly(10'd5);
    doRead(10'd5, 10'd3, 2'b11, 2);

    for (int n = 0; n < 200; n++) begin
      logic [9:0]  r, c;
      logic [1:0]  l;
      logic [15:0] d;
      int op;
      op = int'($urandom % 5);
      r  = 10'($urandom);
      c  = 10'($urandom);
      l  = 2'(1 + $urandom % 3);
      d  = 16'($urandom);
      case (op)
        0: doRead(r, c, l, int'($urandom % 3));
        1: doEarlyWrite(r, c, l, d);
        2: doRmw(r, c, l, d);
        3: doCbr(1'b1);
        default: doRasOnly(r);
      endcase
    end

    while (refCnt != 0) doCbr(1'b0);
    chkEq("R8 counter wrap", 32'(refreshCount), 32'd0);

    finished = 1;
    summary;
    $finish;
  end
endmodule